// File: doc/BRIEF.md
# Accumulator Convergent Rounding Stage

This stage takes a 40-bit multiply-accumulate value and rounds it to the weight of bit 16. The value arrives as three fields: an 8-bit top field, a 16-bit middle field and a 16-bit low field. Rounding adds one half, which is 2^15, and lets the carry run up through the top field.

By default a tie is resolved toward an even middle field. A tie is a low field of exactly 0x8000. A mode input switches the stage to plain round-half-up. That mode changes only the result of a tie.

An instruction-level round enable selects between the rounded value and the raw value. A destination select picks where the result goes. One choice is a full 40-bit result register. The other is a 16-bit feedback register, which takes only the middle field. Results are registered one clock after a valid strobe.

Top module: `acc_round_stage`

## Requirements
- R1: While `rst_n` is low, all outputs (`res_top`, `res_mid`, `res_low`, `fb_out`) are zero.
- R2: With `rnd_en`=1, the rounded sum is S = {top,mid,low} + 0x8000, taken over 40 bits, with the carry running through bits 16 to 39. A full-register load writes `res_top`=S[39:32], `res_mid`=S[31:16] and `res_low`=S[15:0].
- R3: In both modes, a low field below 0x8000 leaves the middle field of S equal to the input middle field. A low field above 0x8000 makes it the input middle field plus one.
- R4: With `bias_mode`=0, a low field of exactly 0x8000 forces bit 16 of S to 0 after the increment. An odd middle field therefore rounds up and an even one stays, and the resulting middle field is always even.
- R5: With `bias_mode`=1, a low field of exactly 0x8000 always rounds up. A middle field of 0x0000 gives 0x0001 in this mode and 0x0000 in the default mode. A middle field of 0x0001 gives 0x0002 in both modes.
- R6: With `dest_sel`=1 (feedback), `fb_out` is loaded with S[31:16].
- R7: With `rnd_en`=0, the selected destination is loaded with the unmodified fields. Here S equals the input value, and `bias_mode` has no effect.
- R8: The carry out of bit 39 is discarded and no saturation is applied. For example, 0xFF_FFFF_C000 rounds to 0x00_0000_4000.
- R9: Outputs change only on the clock edge that samples `in_valid`=1, and become visible one cycle after the strobe. With `in_valid`=0, every output holds.
- R10: `dest_sel`=0 loads only the full result register. `dest_sel`=1 loads only `fb_out`. The register that is not selected keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Load strobe for the selected destination |
| rnd_en | input | 1 | 1 = round the value, 0 = pass it through |
| dest_sel | input | 1 | 0 = full result register, 1 = feedback register |
| bias_mode | input | 1 | 0 = ties to even, 1 = ties round up |
| acc_top | input | 8 | Accumulator bits 39:32 |
| acc_mid | input | 16 | Accumulator bits 31:16 |
| acc_low | input | 16 | Accumulator bits 15:0 |
| res_top | output | 8 | Full result, bits 39:32 |
| res_mid | output | 16 | Full result, bits 31:16 |
| res_low | output | 16 | Full result, bits 15:0 |
| fb_out | output | 16 | Feedback register, the rounded middle field |

## Verification
The assertions assume that the control inputs and the accumulator fields are stable and known around each sampling edge. They also assume that each strobe's result is judged only against the inputs from that same edge. The stimulus changes all inputs on the falling edge and holds `in_valid` high for exactly one cycle per operation, with an idle cycle in between. The sweeps cover middle fields that are odd and even, at zero and at full scale, and low fields on both sides of and exactly at the half point. This keeps every tie, carry-ripple and wrap case within the assumptions while the assertions are active.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
  typedef enum logic {
    DEST_FULL = 1'b0,
    DEST_FB   = 1'b1
  } dest_e;
endpackage

// File: rtl/rnd_tie_detect.sv
module rnd_tie_detect #(
  parameter int LOW_W = 16
) (
  input  logic [LOW_W-1:0] low_i,
  output logic             tie_o
);
  localparam logic [LOW_W-1:0] HALF = {1'b1, {(LOW_W-1){1'b0}}};

  always_comb begin
    tie_o = (low_i == HALF);
  end
endmodule

// File: rtl/rnd_adder.sv
module rnd_adder #(
  parameter int ACC_W = 40,
  parameter int LOW_W = 16
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic             rnd_en_i,
  input  logic             tie_i,
  input  logic             bias_i,
  output logic [ACC_W-1:0] sum_o
);
  localparam logic [ACC_W-1:0] INC =
    {{(ACC_W-LOW_W){1'b0}}, 1'b1, {(LOW_W-1){1'b0}}};

  logic [ACC_W-1:0] raw_sum;
  logic             clear_even;

  always_comb begin
    raw_sum    = acc_i + (rnd_en_i ? INC : '0);
    clear_even = rnd_en_i & tie_i & ~bias_i;
    sum_o      = raw_sum;
    if (clear_even) begin
      sum_o[LOW_W] = 1'b0;
    end
  end
endmodule

// File: rtl/rnd_dest_regs.sv
module rnd_dest_regs #(
  parameter int TOP_W = 8,
  parameter int MID_W = 16,
  parameter int LOW_W = 16,
  localparam int ACC_W = TOP_W + MID_W + LOW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_full_i,
  input  logic             load_fb_i,
  input  logic [ACC_W-1:0] sum_i,
  output logic [ACC_W-1:0] full_o,
  output logic [MID_W-1:0] fb_o
);
  logic [ACC_W-1:0] full_q, full_nxt;
  logic [MID_W-1:0] fb_q, fb_nxt;

  always_comb begin
    full_nxt = full_q;
    fb_nxt   = fb_q;
    if (load_full_i) begin
      full_nxt = sum_i;
    end
    if (load_fb_i) begin
      fb_nxt = sum_i[LOW_W +: MID_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
      fb_q   <= '0;
    end else begin
      full_q <= full_nxt;
      fb_q   <= fb_nxt;
    end
  end

  assign full_o = full_q;
  assign fb_o   = fb_q;
endmodule

// File: rtl/acc_round_stage.sv
module acc_round_stage
  import rnd_pkg::*;
#(
  parameter int TOP_W = 8,
  parameter int MID_W = 16,
  parameter int LOW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             rnd_en,
  input  logic             dest_sel,
  input  logic             bias_mode,
  input  logic [TOP_W-1:0] acc_top,
  input  logic [MID_W-1:0] acc_mid,
  input  logic [LOW_W-1:0] acc_low,
  output logic [TOP_W-1:0] res_top,
  output logic [MID_W-1:0] res_mid,
  output logic [LOW_W-1:0] res_low,
  output logic [MID_W-1:0] fb_out
);
  localparam int ACC_W = TOP_W + MID_W + LOW_W;

  logic [ACC_W-1:0] acc_word;
  logic [ACC_W-1:0] sum_word;
  logic [ACC_W-1:0] full_word;
  logic             tie_seen;
  logic             load_full;
  logic             load_fb;
  dest_e            dest;

  always_comb begin
    acc_word  = {acc_top, acc_mid, acc_low};
    dest      = dest_e'(dest_sel);
    load_full = in_valid & (dest == DEST_FULL);
    load_fb   = in_valid & (dest == DEST_FB);
  end

  rnd_tie_detect #(.LOW_W(LOW_W)) tie_i (
    .low_i (acc_low),
    .tie_o (tie_seen)
  );

  rnd_adder #(.ACC_W(ACC_W), .LOW_W(LOW_W)) add_i (
    .acc_i    (acc_word),
    .rnd_en_i (rnd_en),
    .tie_i    (tie_seen),
    .bias_i   (bias_mode),
    .sum_o    (sum_word)
  );

  rnd_dest_regs #(.TOP_W(TOP_W), .MID_W(MID_W), .LOW_W(LOW_W)) regs_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_full_i (load_full),
    .load_fb_i   (load_fb),
    .sum_i       (sum_word),
    .full_o      (full_word),
    .fb_o        (fb_out)
  );

  assign res_top = full_word[LOW_W+MID_W +: TOP_W];
  assign res_mid = full_word[LOW_W +: MID_W];
  assign res_low = full_word[0 +: LOW_W];
endmodule

// File: rtl/acc_round_stage_chk.sv
module acc_round_stage_chk #(
  parameter int TOP_W = 8,
  parameter int MID_W = 16,
  parameter int LOW_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             rnd_en,
  input logic             dest_sel,
  input logic             bias_mode,
  input logic [TOP_W-1:0] acc_top,
  input logic [MID_W-1:0] acc_mid,
  input logic [LOW_W-1:0] acc_low,
  input logic [TOP_W-1:0] res_top,
  input logic [MID_W-1:0] res_mid,
  input logic [LOW_W-1:0] res_low,
  input logic [MID_W-1:0] fb_out
);
  localparam logic [LOW_W-1:0] HALF = {1'b1, {(LOW_W-1){1'b0}}};

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(res_top) && $stable(res_mid) && $stable(res_low) && $stable(fb_out))); // R9
  AST_FB_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dest_sel) |=> $stable(fb_out)); // R10
  AST_FULL_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dest_sel) |=> ($stable(res_top) && $stable(res_mid) && $stable(res_low))); // R10
  AST_BYPASS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !rnd_en && !dest_sel) |=>
      ({res_top, res_mid, res_low} == $past({acc_top, acc_mid, acc_low}))); // R7
  AST_TIE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rnd_en && dest_sel && !bias_mode && acc_low == HALF) |=> !fb_out[0]); // R4
  AST_TIE_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rnd_en && dest_sel && bias_mode && acc_low == HALF) |=>
      (fb_out == MID_W'($past(acc_mid) + 1'b1))); // R5
  AST_BELOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rnd_en && dest_sel && acc_low < HALF) |=> (fb_out == $past(acc_mid))); // R3
  AST_ABOVE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rnd_en && dest_sel && acc_low > HALF) |=>
      (fb_out == MID_W'($past(acc_mid) + 1'b1))); // R3
endmodule

bind acc_round_stage acc_round_stage_chk #(
  .TOP_W(TOP_W), .MID_W(MID_W), .LOW_W(LOW_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .rnd_en    (rnd_en),
  .dest_sel  (dest_sel),
  .bias_mode (bias_mode),
  .acc_top   (acc_top),
  .acc_mid   (acc_mid),
  .acc_low   (acc_low),
  .res_top   (res_top),
  .res_mid   (res_mid),
  .res_low   (res_low),
  .fb_out    (fb_out)
);

// File: tb/acc_round_stage_tb_top.sv
module acc_round_stage_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        rnd_en = 1'b0;
  logic        dest_sel = 1'b0;
  logic        bias_mode = 1'b0;
  logic [7:0]  acc_top = '0;
  logic [15:0] acc_mid = '0;
  logic [15:0] acc_low = '0;
  logic [7:0]  res_top;
  logic [15:0] res_mid;
  logic [15:0] res_low;
  logic [15:0] fb_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [39:0] exp_full = '0;
  logic [15:0] exp_fb = '0;

  always #4 clk = ~clk;

  acc_round_stage dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rnd_en(rnd_en),
    .dest_sel(dest_sel), .bias_mode(bias_mode), .acc_top(acc_top),
    .acc_mid(acc_mid), .acc_low(acc_low), .res_top(res_top),
    .res_mid(res_mid), .res_low(res_low), .fb_out(fb_out)
  );

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] model(input logic [39:0] v, input logic en, input logic bias);
    logic [39:0] s;
    s = v + (en ? 40'h8000 : 40'h0);
    if (en && !bias && v[15:0] == 16'h8000) s[16] = 1'b0;
    return s;
  endfunction

  task automatic apply(input string req, input logic en, input logic dsel, input logic bias,
                       input logic [7:0] t, input logic [15:0] m, input logic [15:0] l);
    logic [39:0] s;
    @(negedge clk);
    in_valid = 1'b1; rnd_en = en; dest_sel = dsel; bias_mode = bias;
    acc_top = t; acc_mid = m; acc_low = l;
    s = model({t, m, l}, en, bias);
    if (dsel) exp_fb = s[31:16];
    else exp_full = s;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " full"}, {res_top, res_mid, res_low}, exp_full);
    check({req, " fb"}, {24'h0, fb_out}, {24'h0, exp_fb});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0]  tops [3];
    logic [15:0] mids [8];
    logic [15:0] lows [10];
    string req;
    tops = '{8'h00, 8'h7F, 8'hFF};
    mids = '{16'h0000, 16'h0001, 16'h0002, 16'h0003, 16'h7FFF, 16'h8000, 16'hFFFE, 16'hFFFF};
    lows = '{16'h0000, 16'h0001, 16'h4000, 16'h7FFF, 16'h8000, 16'h8001, 16'hC000, 16'hFFFF, 16'h7FFE, 16'h8002};

    repeat (3) @(negedge clk);
    check("R1 reset", {res_top, res_mid, res_low}, 40'h0);
    check("R1 reset fb", {24'h0, fb_out}, 40'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // directed vectors for the tie cases
    apply("R5 biased tie even", 1'b1, 1'b1, 1'b1, 8'h00, 16'h0000, 16'h8000);
    check("R5 mid0 biased", {24'h0, fb_out}, 40'h1);
    apply("R4 unbiased tie even", 1'b1, 1'b1, 1'b0, 8'h00, 16'h0000, 16'h8000);
    check("R4 mid0 unbiased", {24'h0, fb_out}, 40'h0);
    apply("R4 unbiased tie odd", 1'b1, 1'b1, 1'b0, 8'h00, 16'h0001, 16'h8000);
    check("R4 mid1 unbiased", {24'h0, fb_out}, 40'h2);
    apply("R5 biased tie odd", 1'b1, 1'b1, 1'b1, 8'h00, 16'h0001, 16'h8000);
    check("R5 mid1 biased", {24'h0, fb_out}, 40'h2);
    // wrap past bit 39
    apply("R8 wrap", 1'b1, 1'b0, 1'b0, 8'hFF, 16'hFFFF, 16'hC000);
    check("R8 wrap value", {res_top, res_mid, res_low}, 40'h00_0000_4000);
    // carry into top field
    apply("R2 carry to top", 1'b1, 1'b0, 1'b1, 8'h12, 16'hFFFF, 16'h8001);
    check("R2 carry value", {res_top, res_mid, res_low}, 40'h13_0000_0001);
    // feedback load leaves full register alone
    apply("R10 fb only", 1'b1, 1'b1, 1'b0, 8'h55, 16'h1234, 16'h9000);
    check("R10 full kept", {res_top, res_mid, res_low}, 40'h13_0000_0001);
    check("R6 fb value", {24'h0, fb_out}, 40'h1235);

    // idle cycles with changing inputs
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      acc_top = 8'(k * 37); acc_mid = 16'(k * 4099); acc_low = 16'(k * 9001);
      rnd_en = k[0]; dest_sel = k[1]; bias_mode = k[2];
      @(negedge clk);
      check("R9 idle full", {res_top, res_mid, res_low}, exp_full);
      check("R9 idle fb", {24'h0, fb_out}, {24'h0, exp_fb});
    end

    // sweep
    for (int ti = 0; ti < 3; ti++)
      for (int mi = 0; mi < 8; mi++)
        for (int li = 0; li < 10; li++)
          for (int c = 0; c < 8; c++) begin
            if (c[0] == 1'b0) req = "R7 bypass";
            else if (lows[li] == 16'h8000) req = c[2] ? "R5 tie" : "R4 tie";
            else req = "R3 nontie";
            if (c[1]) req = {req, " R6"};
            else req = {req, " R2"};
            apply(req, c[0], c[1], c[2], tops[ti], mids[mi], lows[li]);
          end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule